// File: doc/BRIEF.md
# Differential Phase Modulator with Sampled Carrier

This block turns a serial stream of data bits into signed carrier samples in which the information sits in the phase change from one bit period to the next. Each accepted bit is passed through a differential encoder whose memory is the previously transmitted symbol. The resulting symbol picks either the stored carrier waveform (phase 0) or its two's-complement negation (phase π) for one whole bit period. A receiver that multiplies the signal by a copy delayed by one bit period recovers the data without a local carrier.

After reset the block first sends one full period of a reference symbol of value 1, and only then transmits the encoded data. A data bit is taken through a valid/ready handshake, and only on the last sample of a period. If no bit is offered at that moment, the next period is silent (all-zero samples) and the encoder memory is kept. Samples are produced at the rate of a clock enable and are registered, each with a valid strobe.

Top module: `diffphase_tx`

## Requirements
- R1: While reset is asserted, and in the clock after the reset input falls, `out_valid` is 0, `out_sample` is 0 and `in_ready` is 0.
- R2: The first bit period after reset carries symbol 1 (phase 0), before any data bit is accepted.
- R3: The symbol for an accepted bit is the XNOR of the data bit and the previous symbol: data 1 keeps the carrier phase, data 0 reverses it.
- R4: In sample k (0 to 15) of a period, symbol 1 gives round(2047·sin(2πk/16)) and symbol 0 gives the negation of that value, one full carrier cycle per bit period.
- R5: `in_ready` is 1 only in an enabled cycle holding the last sample of a period (the 16th enabled cycle of each period with the default setting).
- R6: If `in_valid` is 0 when `in_ready` is 1, the next period outputs all-zero samples and the next accepted bit is encoded against the last symbol sent before the gap.
- R7: In a cycle with `ce` low nothing advances: `out_valid` is 0 in the next cycle, `out_sample` holds, and the sample sequence continues where it stopped.
- R8: Each enabled cycle yields exactly one sample, shown with `out_valid` = 1 one clock later.
- R9: `out_sample` never takes the most negative code (-2048).
- R10: A reset during transmission discards the period in progress and restarts with the reference period of symbol 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce | input | 1 | Sample-rate clock enable |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Data bit |
| in_ready | output | 1 | Bit is taken in this cycle if `in_valid` is high |
| out_valid | output | 1 | `out_sample` holds a new sample |
| out_sample | output | 12 | Signed carrier sample |

## Verification
A vector walk sends the bit string 0 0 1 0 0 1 0 0 1 1 1, which has runs of equal bits as well as alternations, so a swapped XNOR/XOR rule or a wrong reference value shows as phase errors in whole periods of samples. A gap with no offered bit tells apart a design that keeps its encoder memory from one that resets or advances it, because the following bit is encoded against the symbol sent before the gap. Clock-enable stalls placed inside a period separate a design that counts enabled samples from one that counts clocks, and a reset in mid-period checks that the reference period comes back.

// File: rtl/diffphase_pkg.sv
package diffphase_pkg;

  localparam int SAMPLE_W  = 12;
  localparam int TABLE_LEN = 16;
  localparam int TABLE_AW  = $clog2(TABLE_LEN);

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  // One carrier cycle, amplitude 2047; the code -2048 is never stored,
  // so negating any entry stays in range.
  function automatic sample_t carrier_at(input logic [TABLE_AW-1:0] idx);
    sample_t v;
    case (idx)
      4'd0:  v = 12'sd0;
      4'd1:  v = 12'sd783;
      4'd2:  v = 12'sd1447;
      4'd3:  v = 12'sd1891;
      4'd4:  v = 12'sd2047;
      4'd5:  v = 12'sd1891;
      4'd6:  v = 12'sd1447;
      4'd7:  v = 12'sd783;
      4'd8:  v = 12'sd0;
      4'd9:  v = -12'sd783;
      4'd10: v = -12'sd1447;
      4'd11: v = -12'sd1891;
      4'd12: v = -12'sd2047;
      4'd13: v = -12'sd1891;
      4'd14: v = -12'sd1447;
      default: v = -12'sd783;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/diffphase_enc.sv
module diffphase_enc #(
  parameter int SAMPLES_PER_BIT = 16,
  localparam int CNT_W = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             sym_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sym_q, sym_d;
  logic             act_q, act_d;
  logic             last;

  always_comb begin
    last     = (cnt_q == CNT_W'(SAMPLES_PER_BIT - 1));
    in_ready = ce & last;
    cnt_d    = cnt_q;
    sym_d    = sym_q;
    act_d    = act_q;
    if (ce) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
      if (last) begin
        if (in_valid) begin
          sym_d = ~(in_bit ^ sym_q);
          act_d = 1'b1;
        end else begin
          act_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sym_q <= 1'b1;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sym_q <= sym_d;
      act_q <= act_d;
    end
  end

  assign sym_o    = sym_q;
  assign active_o = act_q;
  assign cnt_o    = cnt_q;

  // R3: data 1 keeps the symbol, data 0 flips it
  assert_one_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && in_bit) |=> $stable(sym_o));
  assert_zero_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && !in_bit) |=> (sym_o != $past(sym_o)));
  // R5: a taken bit starts a fresh period
  assert_ready_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (cnt_o == '0));
  // R6: a missed boundary gives a silent period and keeps the encoder memory
  assert_hold_on_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (!active_o && $stable(sym_o)));
  // R7: no progress without the enable
  assert_ce_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(cnt_o) && $stable(sym_o) && $stable(active_o)));

endmodule

// File: rtl/diffphase_wave.sv
module diffphase_wave
  import diffphase_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16,
  localparam int CNT_W = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             sym_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             out_valid,
  output sample_t          out_sample
);

  logic [TABLE_AW-1:0] idx;
  sample_t             mag;
  sample_t             sample_d;
  sample_t             sample_q;
  logic                valid_q;

  always_comb begin
    idx      = TABLE_AW'((int'(cnt_i) * TABLE_LEN) / SAMPLES_PER_BIT);
    mag      = carrier_at(idx);
    sample_d = '0;
    if (active_i) sample_d = sym_i ? mag : -mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q <= ce;
      if (ce) sample_q <= sample_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_sample = sample_q;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_sample != {1'b1, {(SAMPLE_W-1){1'b0}}});
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !active_i) |=> (out_sample == '0));
  assert_valid_follows_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> out_valid);
  assert_hold_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (!out_valid && $stable(out_sample)));

endmodule

// File: rtl/diffphase_tx.sv
module diffphase_tx
  import diffphase_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                in_valid,
  input  logic                in_bit,
  output logic                in_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);

  localparam int CNT_W = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             sym;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             ready_raw;
  sample_t          sample;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  diffphase_enc #(.SAMPLES_PER_BIT(SAMPLES_PER_BIT)) u_enc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ce       (ce),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_ready (ready_raw),
    .sym_o    (sym),
    .active_o (active),
    .cnt_o    (cnt)
  );

  diffphase_wave #(.SAMPLES_PER_BIT(SAMPLES_PER_BIT)) u_wave (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ce         (ce),
    .sym_i      (sym),
    .active_i   (active),
    .cnt_i      (cnt),
    .out_valid  (out_valid),
    .out_sample (sample)
  );

  assign in_ready   = ready_raw & rst_int_n;
  assign out_sample = sample;

  // R1: nothing leaves the block while reset is held
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !in_ready));

endmodule

// File: tb/diffphase_tx_test.sv
`timescale 1ns/1ps
module diffphase_tx_test;

  localparam int    SPB = 16;
  localparam real   PI  = 3.14159265358979;
  // {data bit, expected symbol}, starting from the reference symbol 1
  localparam logic [1:0] VEC [11] = '{
    2'b00, 2'b01, 2'b11, 2'b00, 2'b01, 2'b11,
    2'b00, 2'b01, 2'b11, 2'b11, 2'b11
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce;
  logic              in_valid;
  logic              in_bit;
  logic              in_ready;
  logic              out_valid;
  logic signed [11:0] out_sample;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  diffphase_tx #(.SAMPLES_PER_BIT(SPB)) uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic int tab(input int k);
    return int'($floor(2047.0 * $sin(2.0 * PI * k / 16.0) + 0.5));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One bit period: presents (v,b) for the next boundary and checks the
  // samples of the current period, symbol sym, silent when act is 0.
  task automatic period(input bit v, input bit b, input bit act, input bit sym,
                        input int gap_at, input string tag);
    for (int k = 0; k < SPB; k++) begin
      int e;
      @(negedge clk);
      ce = 1'b1; in_valid = v; in_bit = b;
      #1 check("R5 ready", int'(in_ready), (k == SPB - 1) ? 1 : 0);
      @(posedge clk); #1;
      e = act ? (sym ? tab(k) : -tab(k)) : 0;
      check("R8 valid", int'(out_valid), 1);
      check(tag, int'(out_sample), e);
      check("R9 no min code", (int'(out_sample) == -2048) ? 1 : 0, 0);
      if (k == gap_at) begin
        for (int g = 0; g < 3; g++) begin
          @(negedge clk);
          ce = 1'b0;
          #1 check("R7 ready", int'(in_ready), 0);
          @(posedge clk); #1;
          check("R7 valid", int'(out_valid), 0);
          check("R7 hold", int'(out_sample), e);
        end
      end
    end
  endtask

  task automatic start_up();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit prev;
    rst_n = 1'b0; ce = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    #1;
    check("R1 valid", int'(out_valid), 0);
    check("R1 sample", int'(out_sample), 0);
    check("R1 ready", int'(in_ready), 0);
    repeat (2) @(posedge clk);
    start_up();

    // vector walk: reference period first, then the encoded bits
    prev = 1'b1;
    for (int i = 0; i < 11; i++) begin
      period(1'b1, VEC[i][1], 1'b1, prev, -1, (i == 0) ? "R2 reference" : "R3 encode");
      prev = VEC[i][0];
    end
    period(1'b0, 1'b0, 1'b1, prev, -1, "R4 phase");     // last symbol, nothing offered
    period(1'b1, 1'b0, 1'b0, prev, -1, "R6 silent");    // gap period
    period(1'b0, 1'b0, 1'b1, ~(1'b0 ^ prev), 5, "R6 memory kept");
    period(1'b0, 1'b0, 1'b0, 1'b0, -1, "R6 silent again");

    // reset in the middle of a period
    repeat (4) begin
      @(negedge clk); ce = 1'b1; in_valid = 1'b1; in_bit = 1'b0;
    end
    @(negedge clk);
    rst_n = 1'b0; ce = 1'b0;
    #1;
    check("R1 valid mid", int'(out_valid), 0);
    check("R1 sample mid", int'(out_sample), 0);
    check("R1 ready mid", int'(in_ready), 0);
    @(posedge clk); #1;
    check("R1 valid next", int'(out_valid), 0);
    start_up();
    period(1'b1, 1'b1, 1'b1, 1'b1, -1, "R10 reference again");
    period(1'b0, 1'b0, 1'b1, 1'b1, 2, "R10 data 1 keeps phase");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule